// File: doc/BRIEF.md
# Winograd F(2x2,3x3) Convolution Engine

This engine turns one 4x4 patch of a feature map per input channel into a 2x2 patch of the output map. It does not multiply and accumulate directly. It converts each patch into a transformed domain using only additions and subtractions, multiplies that result element by element with a filter already in the transformed domain, and adds the products of all channel lanes together. A final inverse transform then produces four outputs. Each 2x2 output needs 16 multiplies per channel, where direct convolution would need 36.

Each channel lane keeps its own 4x4 transformed filter. The filters are written one lane at a time through a load port, and a lane keeps its filter until it is written again. One tile bundle, carrying one patch per lane, can be accepted every cycle. Results appear in the order the tiles arrived, after a fixed delay, as signed fixed-point values. They are scaled down by an arithmetic right shift and clamped to the output width.

Top module: `wg_pe`

## Requirements
- R1: When `rst_n` is asserted and on the first clock after it is released, `out_vld` is 0.
- R2: A tile accepted with `tile_vld`=1 on a clock edge produces exactly one result with `out_vld`=1 three edges later. A new tile can be accepted on every edge, and results come out in the order the tiles arrived.
- R3: Lane l's patch element (r,c) is at `tile_data[((l*16)+r*4+c)*DW +: DW]`, and output (i,j) is at `out_data[(i*2+j)*DW +: DW]`. The result is sat((sum over lanes of A'·((B'·d·B)⊙U)·A) >>> SHIFT), with B' = [[1,0,-1,0],[0,1,1,0],[0,-1,1,0],[0,1,0,-1]] and A' = [[1,1,1,0],[0,1,-1,-1]]. With U = Gs·g·Gs' (Gs = [[2,0,0],[1,1,1],[1,-1,1],[0,0,2]]) and SHIFT=2, this equals the stride-1 3x3 correlation of d with g, summed over the lanes.
- R4: All data words are two's-complement signed. Element-wise products, the lane sum and the inverse transform are formed at AW bits.
- R5: With `flt_we`=1, `flt_data` is written into the filter of lane `flt_sel`. Element (r,c) is at `flt_data[(r*4+c)*DW +: DW]`. A tile accepted on the same edge as a load still uses that lane's previous filter. Later tiles use the new one.
- R6: A shifted result above 2^(DW-1)-1 or below -2^(DW-1) is clamped to that limit.
- R7: `out_data` keeps its value on every edge that does not produce a result, even while filters are being loaded.
- R8: A filter load changes only the lane that `flt_sel` selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tile_vld | input | 1 | Tile bundle present |
| tile_data | input | LANES*16*DW | One 4x4 patch per lane |
| flt_we | input | 1 | Filter write strobe |
| flt_sel | input | SW | Lane whose filter is written |
| flt_data | input | 16*DW | Transformed 4x4 filter |
| out_vld | output | 1 | Result present |
| out_data | output | 4*DW | 2x2 output patch |

## Verification
The bench builds the engine with its defaults: LANES=4, DW=16, AW=32, SHIFT=2. It prepares each filter with the scaled integer transform, so the transformed weights are four times the true ones and a shift of 2 removes that factor exactly. This lets every result be compared directly with a plain four-lane 3x3 correlation computed in the bench. Patches of plus or minus 2000 with large weights drive the lane sum beyond 16 bits in both directions, which exercises the clamp. Four lanes make it possible to load one lane on the same edge as a tile, and to reload one lane while the others keep their filters.

// File: rtl/wg_pkg.sv
package wg_pkg;
  localparam int TDIM = 4;            // input patch edge
  localparam int ODIM = 2;            // output patch edge
  localparam int NTE  = TDIM * TDIM;  // elements per patch
  localparam int NOE  = ODIM * ODIM;  // elements per result
endpackage

// File: rtl/wg_in_xform.sv
// Input-side transform: two passes of add/subtract over a 4x4 patch.
module wg_in_xform
  import wg_pkg::*;
#(
  parameter int DW = 16,
  parameter int VW = DW + 2
) (
  input  logic [NTE*DW-1:0] patch,
  output logic [NTE*VW-1:0] xpatch
);
  logic signed [VW-1:0] dd [TDIM][TDIM];
  logic signed [VW-1:0] tt [TDIM][TDIM];
  logic signed [VW-1:0] vv [TDIM][TDIM];

  always_comb begin
    for (int r = 0; r < TDIM; r++)
      for (int c = 0; c < TDIM; c++)
        dd[r][c] = VW'($signed(patch[(r*TDIM+c)*DW +: DW]));
    // row combination
    for (int c = 0; c < TDIM; c++) begin
      tt[0][c] = dd[0][c] - dd[2][c];
      tt[1][c] = dd[1][c] + dd[2][c];
      tt[2][c] = dd[2][c] - dd[1][c];
      tt[3][c] = dd[1][c] - dd[3][c];
    end
    // column combination
    for (int r = 0; r < TDIM; r++) begin
      vv[r][0] = tt[r][0] - tt[r][2];
      vv[r][1] = tt[r][1] + tt[r][2];
      vv[r][2] = tt[r][2] - tt[r][1];
      vv[r][3] = tt[r][1] - tt[r][3];
    end
    for (int r = 0; r < TDIM; r++)
      for (int c = 0; c < TDIM; c++)
        xpatch[(r*TDIM+c)*VW +: VW] = vv[r][c];
  end
endmodule

// File: rtl/wg_lane.sv
// One channel lane: filter store, input transform, element-wise product stage.
module wg_lane
  import wg_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              ld_en,
  input  logic [NTE*DW-1:0] ld_data,
  input  logic              tile_en,
  input  logic [NTE*DW-1:0] tile,
  output logic [NTE*AW-1:0] prod
);
  localparam int VW = DW + 2;

  logic [NTE*DW-1:0] flt_q;
  logic [NTE*VW-1:0] xtile;
  logic [NTE*AW-1:0] prod_d;
  logic [NTE*AW-1:0] prod_q;

  wg_in_xform #(.DW(DW), .VW(VW)) u_xf (.patch(tile), .xpatch(xtile));

  always_comb begin
    for (int k = 0; k < NTE; k++) begin
      logic signed [AW-1:0] a;
      logic signed [AW-1:0] b;
      a = AW'($signed(xtile[k*VW +: VW]));
      b = AW'($signed(flt_q[k*DW +: DW]));
      prod_d[k*AW +: AW] = a * b;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) flt_q <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (tile_en) prod_q <= prod_d;
  end

  assign prod = prod_q;
endmodule

// File: rtl/wg_out_xform.sv
// Inverse transform, arithmetic scale-down and clamp to DW.
module wg_out_xform
  import wg_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 32,
  parameter int SHIFT = 2
) (
  input  logic [NTE*AW-1:0] msum,
  output logic [NOE*DW-1:0] res
);
  localparam logic signed [AW-1:0] MAXV = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [AW-1:0] mm [TDIM][TDIM];
  logic signed [AW-1:0] rr [ODIM][TDIM];
  logic signed [AW-1:0] yy [ODIM][ODIM];

  always_comb begin
    for (int r = 0; r < TDIM; r++)
      for (int c = 0; c < TDIM; c++)
        mm[r][c] = $signed(msum[(r*TDIM+c)*AW +: AW]);
    for (int c = 0; c < TDIM; c++) begin
      rr[0][c] = mm[0][c] + mm[1][c] + mm[2][c];
      rr[1][c] = mm[1][c] - mm[2][c] - mm[3][c];
    end
    for (int i = 0; i < ODIM; i++) begin
      yy[i][0] = rr[i][0] + rr[i][1] + rr[i][2];
      yy[i][1] = rr[i][1] - rr[i][2] - rr[i][3];
    end
    for (int i = 0; i < ODIM; i++)
      for (int j = 0; j < ODIM; j++) begin
        logic signed [AW-1:0] sh;
        sh = yy[i][j] >>> SHIFT;
        if (sh > MAXV)      sh = MAXV;
        else if (sh < MINV) sh = MINV;
        res[(i*ODIM+j)*DW +: DW] = sh[DW-1:0];
      end
  end
endmodule

// File: rtl/wg_pe.sv
// Top: parallel channel lanes, lane sum, inverse transform. Latency 3.
module wg_pe
  import wg_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 16,
  parameter int AW    = 32,
  parameter int SHIFT = 2,
  localparam int SW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tile_vld,
  input  logic [LANES*NTE*DW-1:0] tile_data,
  input  logic                    flt_we,
  input  logic [SW-1:0]           flt_sel,
  input  logic [NTE*DW-1:0]       flt_data,
  output logic                    out_vld,
  output logic [NOE*DW-1:0]       out_data
);
  logic [NTE*AW-1:0] prod [LANES];
  logic [NTE*AW-1:0] sum_d;
  logic [NTE*AW-1:0] sum_q;
  logic [NOE*DW-1:0] res_d;
  logic [NOE*DW-1:0] res_q;
  logic              s1_vld;
  logic              s2_vld;
  logic              vld_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic ld_hit;
    assign ld_hit = flt_we && (flt_sel == SW'(l));
    wg_lane #(.DW(DW), .AW(AW)) u_lane (
      .clk     (clk),
      .ld_en   (ld_hit),
      .ld_data (flt_data),
      .tile_en (tile_vld),
      .tile    (tile_data[l*NTE*DW +: NTE*DW]),
      .prod    (prod[l])
    );
  end

  always_comb begin
    for (int k = 0; k < NTE; k++) begin
      logic signed [AW-1:0] acc;
      acc = '0;
      for (int l = 0; l < LANES; l++)
        acc = acc + $signed(prod[l][k*AW +: AW]);
      sum_d[k*AW +: AW] = acc;
    end
  end

  wg_out_xform #(.DW(DW), .AW(AW), .SHIFT(SHIFT)) u_oxf (.msum(sum_q), .res(res_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      s1_vld <= tile_vld;
      s2_vld <= s1_vld;
      vld_q  <= s2_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_vld) sum_q <= sum_d;
  end

  always_ff @(posedge clk) begin
    if (s2_vld) res_q <= res_d;
  end

  assign out_vld  = vld_q;
  assign out_data = res_q;
endmodule

// File: rtl/wg_pe_chk.sv
module wg_pe_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tile_vld,
  input logic          s1_vld,
  input logic          s2_vld,
  input logic          out_vld,
  input logic [4*DW-1:0] out_data
);
  always @(posedge clk) begin
    if (!rst_n) begin
      // R1
      rst_quiet_chk: assert (!out_vld);
    end
  end

  // R2
  lat_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tile_vld, 3) |-> out_vld);

  // R2
  lat_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(tile_vld, 3));

  // R2
  pipe_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> s2_vld);

  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_vld |=> $stable(out_data));
endmodule

bind wg_pe wg_pe_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tile_vld (tile_vld),
  .s1_vld   (s1_vld),
  .s2_vld   (s2_vld),
  .out_vld  (out_vld),
  .out_data (out_data)
);

// File: tb/tb_wg_pe.sv
module tb_wg_pe;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int DW    = 16;
  localparam int AW    = 32;
  localparam int SHIFT = 2;
  localparam int SW    = 2;

  logic                   clk;
  logic                   rst_n;
  logic                   tile_vld;
  logic [LANES*16*DW-1:0] tile_data;
  logic                   flt_we;
  logic [SW-1:0]          flt_sel;
  logic [16*DW-1:0]       flt_data;
  logic                   out_vld;
  logic [4*DW-1:0]        out_data;

  wg_pe #(.LANES(LANES), .DW(DW), .AW(AW), .SHIFT(SHIFT)) dut (
    .clk(clk), .rst_n(rst_n), .tile_vld(tile_vld), .tile_data(tile_data),
    .flt_we(flt_we), .flt_sel(flt_sel), .flt_data(flt_data),
    .out_vld(out_vld), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int eq[$];
  int iq[$];
  string tq[$];
  int dt [LANES][4][4];
  int gc [LANES][3][3];
  int gn [3][3];
  bit have_last = 0;
  logic [4*DW-1:0] last_out;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int rnd(int lim);
    return int'($urandom_range(2*lim)) - lim;
  endfunction

  function automatic int sat(longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return int'(x);
  endfunction

  // scaled integer filter transform: U = Gs g Gs'
  function automatic logic [16*DW-1:0] pack_gn();
    int gs [4][3] = '{'{2,0,0}, '{1,1,1}, '{1,-1,1}, '{0,0,2}};
    logic [16*DW-1:0] v;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        int u;
        u = 0;
        for (int a = 0; a < 3; a++)
          for (int b = 0; b < 3; b++)
            u += gs[i][a] * gn[a][b] * gs[j][b];
        v[(i*4+j)*DW +: DW] = DW'(u);
      end
    return v;
  endfunction

  // direct 3x3 correlation summed over lanes
  function automatic int ref_out(int i, int j);
    longint s;
    s = 0;
    for (int l = 0; l < LANES; l++)
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++)
          s += longint'(dt[l][i+a][j+b]) * longint'(gc[l][a][b]);
    return sat(s);
  endfunction

  task automatic fill_gn(int mode, int lim);
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        gn[a][b] = (mode == 1) ? lim : rnd(lim);
  endtask

  task automatic commit_gn(int l);
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        gc[l][a][b] = gn[a][b];
  endtask

  task automatic idle();
    @(negedge clk);
    tile_vld = 1'b0;
    flt_we   = 1'b0;
  endtask

  task automatic load_filter(int l, int mode, int lim);
    @(negedge clk);
    fill_gn(mode, lim);
    tile_vld = 1'b0;
    flt_we   = 1'b1;
    flt_sel  = SW'(l);
    flt_data = pack_gn();
    commit_gn(l);
  endtask

  // mode 0: random within lim, mode 1: every element = lim
  task automatic send_tile(int mode, int lim, bit with_load, int ll, int glim, string tag);
    @(negedge clk);
    for (int l = 0; l < LANES; l++)
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) begin
          dt[l][r][c] = (mode == 1) ? lim : rnd(lim);
          tile_data[(l*16+r*4+c)*DW +: DW] = DW'(dt[l][r][c]);
        end
    tile_vld = 1'b1;
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 2; j++)
        eq.push_back(ref_out(i, j));
    iq.push_back(cyc);
    tq.push_back(tag);
    if (with_load) begin
      fill_gn(0, glim);
      flt_we   = 1'b1;
      flt_sel  = SW'(ll);
      flt_data = pack_gn();
      commit_gn(ll);
    end else begin
      flt_we = 1'b0;
    end
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_vld) begin
        if (eq.size() < 4) begin
          checks++; errors++;
          $display("FAIL R2 unexpected result act=%h exp=none", out_data);
        end else begin
          int iss;
          string tg;
          bit bad;
          iss = iq.pop_front();
          tg  = tq.pop_front();
          checks++;
          if (cyc != iss + 3) begin
            errors++;
            $display("FAIL R2 latency act=%0d exp=%0d", cyc - iss, 3);
          end
          bad = 0;
          for (int k = 0; k < 4; k++) begin
            int e;
            int a;
            e = eq.pop_front();
            a = int'($signed(out_data[k*DW +: DW]));
            if (a != e) begin
              bad = 1;
              $display("FAIL R3 %s elem %0d act=%0d exp=%0d", tg, k, a, e);
            end
          end
          checks++;
          if (bad) errors++;
        end
        last_out  = out_data;
        have_last = 1;
      end else if (have_last) begin
        checks++;
        if (out_data !== last_out) begin
          errors++;
          $display("FAIL R7 hold act=%h exp=%h", out_data, last_out);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<=%0d cycles", cyc, 50000);
      $display("CHECKS %0d ERRORS %0d", checks + 1, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; tile_vld = 1'b0; flt_we = 1'b0; flt_sel = '0;
    tile_data = '0; flt_data = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_vld !== 1'b0) begin
      errors++; $display("FAIL R1 in reset act=%b exp=0", out_vld);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_vld !== 1'b0) begin
      errors++; $display("FAIL R1 after release act=%b exp=0", out_vld);
    end

    // R3 R4: random filters, back-to-back tiles (R2 throughput)
    for (int l = 0; l < LANES; l++) load_filter(l, 0, 7);
    for (int n = 0; n < 8; n++) send_tile(0, 127, 0, 0, 0, "R2");
    repeat (5) idle();

    // R6: positive and negative clamp
    for (int l = 0; l < LANES; l++) load_filter(l, 1, 7);
    send_tile(1, 2000, 0, 0, 0, "R6");
    send_tile(1, -2000, 0, 0, 0, "R6");
    send_tile(1, 3, 0, 0, 0, "R6");
    idle();

    // R5: load on the same edge as a tile
    send_tile(0, 127, 1, 0, 7, "R5");
    send_tile(0, 127, 0, 0, 0, "R5");
    repeat (2) idle();

    // R8: reload a single lane, idle loads keep the output (R7)
    load_filter(2, 0, 7);
    idle();
    send_tile(0, 127, 0, 0, 0, "R8");
    repeat (4) idle();

    // R3: mixed random traffic
    for (int n = 0; n < 300; n++) begin
      int p;
      p = int'($urandom_range(9));
      if (p == 0)      load_filter(int'($urandom_range(LANES-1)), 0, 7);
      else if (p == 1) idle();
      else if (p == 2) send_tile(0, 127, 1, int'($urandom_range(LANES-1)), 7, "R5");
      else             send_tile(0, 255, 0, 0, 0, "R3");
    end
    repeat (6) idle();

    checks++;
    if (eq.size() != 0) begin
      errors++; $display("FAIL R2 missing results act=%0d exp=0", eq.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule